// File: doc/BRIEF.md
# Stepped Variable-Rate Pulse Generator

This block produces a periodic one-clock strobe whose rate is chosen from eleven fixed steps. A speed level, held in a register, moves up or down one step for each press of an up button or a down button. The level stops at the lowest and highest steps. A cycle counter runs against the period that belongs to the current level. Each time the counter reaches that period, the block emits a strobe and the counter starts again. A second output changes state on every strobe, so the chosen rate can be seen on an LED.

Both buttons are ordinary data inputs. They pass through a synchronizer and a rising-edge detector on the single system clock, and no register is ever clocked by a button. A DIVISOR parameter divides every period by the same factor, so a simulation can use short periods while the same code keeps the real rates.

The reset input is asynchronous and active-low. Its release passes through a two-stage synchronizer before it reaches the internal registers.

Top module: `step_rate_pulser`

## Requirements
- R1: While reset is held, and on leaving it, the level is 0 and both the strobe and the toggle output are low. The level never goes above 10.
- R2: One rising edge on the up input raises the level by exactly one when the level is below 10. Holding the button high for several cycles still counts as a single step.
- R3: One rising edge on the down input lowers the level by exactly one when the level is above 0.
- R4: An up edge has no effect at level 10, and a down edge has no effect at level 0.
- R5: When the two rising edges are detected in the same cycle, the level does not change.
- R6: The period P for level L is the base value divided by DIVISOR, with a minimum of 1. The base values for levels 0 to 10 are 250M, 200M, 175M, 150M, 125M, 100M, 75M, 62.5M, 50M, 35M and 25M cycles. The strobe goes high for one cycle when the counter equals P, and the counter then returns to 0, so strobes are P+1 cycles apart.
- R7: The toggle output inverts in the cycle in which the strobe is high. It holds its value in every other cycle.
- R8: A level change clears the counter and suppresses the strobe in that cycle. The first strobe at the new level comes P+1 cycles after the change.
- R9: A new level appears on the level output after the third rising clock edge that follows a change on a button input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| up_i | input | 1 | Raw up button request |
| down_i | input | 1 | Raw down button request |
| pulse_o | output | 1 | One-cycle rate strobe |
| toggle_o | output | 1 | Changes state on every strobe |
| level_o | output | 4 | Current speed level, 0 to 10 |

## Verification
A button change reaches the level output after three rising edges: two for the synchronizer and one for the level register. The strobe and the toggle output move at the same edge at which the counter is found equal to P. A change of level clears the counter at the edge that moves the level. The bench runs a behavioural model that steps at each rising edge and keeps a three-deep history for each button and a two-deep history for reset, so every expected value lands in the cycle in which the design's registers produce it. All outputs are sampled at the falling edge. The directed checks count falling edges from a known event, such as a level change or a strobe, and compare the count against P+1 or against the three-edge latency.

// File: rtl/rategen_pkg.sv
package rategen_pkg;

  localparam int unsigned NUM_LEVELS      = 11;
  localparam int unsigned TOP_LEVEL       = NUM_LEVELS - 1;
  localparam int unsigned LVL_W           = $clog2(NUM_LEVELS);
  localparam int unsigned FALLBACK_PERIOD = 10_000_000;

  // Undivided period in clock cycles for each speed step.
  function automatic int unsigned base_period(input int unsigned lvl);
    case (lvl)
      0:       base_period = 250_000_000;
      1:       base_period = 200_000_000;
      2:       base_period = 175_000_000;
      3:       base_period = 150_000_000;
      4:       base_period = 125_000_000;
      5:       base_period = 100_000_000;
      6:       base_period = 75_000_000;
      7:       base_period = 62_500_000;
      8:       base_period = 50_000_000;
      9:       base_period = 35_000_000;
      10:      base_period = 25_000_000;
      default: base_period = FALLBACK_PERIOD;
    endcase
  endfunction

  // Scaled period; a result of zero is raised to one cycle.
  function automatic int unsigned scaled_period(input int unsigned base,
                                                input int unsigned divisor);
    int unsigned q;
    q = base / divisor;
    scaled_period = (q == 0) ? 1 : q;
  endfunction

endpackage

// File: rtl/rg_btn_edge.sv
module rg_btn_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic rise_o
);

  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], btn_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/rg_level_ctrl.sv
module rg_level_ctrl
  import rategen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_rise_i,
  input  logic             dn_rise_i,
  output logic [LVL_W-1:0] level_o,
  output logic             change_o
);

  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(TOP_LEVEL);
  localparam logic [LVL_W-1:0] LVL_ZERO = '0;
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] lvl_d;
  logic             lvl_en;

  // Next-state logic: one step per accepted edge; both edges together cancel.
  always_comb begin
    lvl_d  = lvl_q;
    lvl_en = 1'b0;
    if (up_rise_i && !dn_rise_i && (lvl_q < LVL_TOP)) begin
      lvl_d  = lvl_q + LVL_ONE;
      lvl_en = 1'b1;
    end else if (dn_rise_i && !up_rise_i && (lvl_q != LVL_ZERO)) begin
      lvl_d  = lvl_q - LVL_ONE;
      lvl_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  assign level_o  = lvl_q;
  assign change_o = lvl_en;

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_TOP); // R1
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_rise_i && !dn_rise_i && lvl_q < LVL_TOP) |=> lvl_q == $past(lvl_q) + LVL_ONE); // R2
  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_rise_i && !up_rise_i && lvl_q != LVL_ZERO) |=> lvl_q == $past(lvl_q) - LVL_ONE); // R3
  AST_SAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == LVL_TOP && up_rise_i) |=> lvl_q == LVL_TOP); // R4
  AST_SAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == LVL_ZERO && dn_rise_i) |=> lvl_q == LVL_ZERO); // R4
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_rise_i && dn_rise_i) |=> $stable(lvl_q)); // R5

endmodule

// File: rtl/rg_period_sel.sv
module rg_period_sel
  import rategen_pkg::*;
#(
  parameter int unsigned DIVISOR = 1,
  parameter int unsigned CNT_W   = 28
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [CNT_W-1:0] period_o
);

  localparam logic [CNT_W-1:0] FALLBACK =
    CNT_W'(scaled_period(FALLBACK_PERIOD, DIVISOR));

  logic [CNT_W-1:0] table_w [NUM_LEVELS];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_entry
    localparam int unsigned ENTRY = scaled_period(base_period(g), DIVISOR);
    assign table_w[g] = CNT_W'(ENTRY);
  end

  // A level code with no table entry selects the fallback period.
  always_comb begin
    period_o = FALLBACK;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (level_i == LVL_W'(i)) begin
        period_o = table_w[i];
      end
    end
  end

endmodule

// File: rtl/rg_pulse_timer.sv
module rg_pulse_timer #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             restart_i,
  output logic             pulse_o,
  output logic             toggle_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             tog_q, tog_d;
  logic             hit;

  always_comb begin
    hit     = (cnt_q == period_i);
    pulse_d = hit && !restart_i;
    if (restart_i || hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    tog_d = tog_q ^ pulse_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      tog_q   <= tog_d;
    end
  end

  assign pulse_o  = pulse_q;
  assign toggle_o = tog_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= period_i); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q); // R6
  AST_PULSE_AT_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> cnt_q == '0); // R6
  AST_TOGGLE_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_q != $past(tog_q)) |-> pulse_q); // R7
  AST_PULSE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (tog_q != $past(tog_q))); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && !pulse_q)); // R8

endmodule

// File: rtl/step_rate_pulser.sv
module step_rate_pulser
  import rategen_pkg::*;
#(
  parameter int unsigned DIVISOR     = 1,
  parameter int unsigned CNT_W       = 28,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             down_i,
  output logic             pulse_o,
  output logic             toggle_o,
  output logic [LVL_W-1:0] level_o
);

  localparam int unsigned NUM_BTN = 2;
  localparam int unsigned BTN_UP  = 0;
  localparam int unsigned BTN_DN  = 1;

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] btn_rise;

  assign btn_raw = {down_i, up_i};

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
    rg_btn_edge #(
      .STAGES(SYNC_STAGES)
    ) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_n_int),
      .btn_i (btn_raw[g]),
      .rise_o(btn_rise[g])
    );
  end

  logic [LVL_W-1:0] level_w;
  logic             level_chg;
  logic [CNT_W-1:0] period_w;

  rg_level_ctrl u_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .up_rise_i(btn_rise[BTN_UP]),
    .dn_rise_i(btn_rise[BTN_DN]),
    .level_o  (level_w),
    .change_o (level_chg)
  );

  rg_period_sel #(
    .DIVISOR(DIVISOR),
    .CNT_W  (CNT_W)
  ) u_period (
    .level_i (level_w),
    .period_o(period_w)
  );

  rg_pulse_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .period_i (period_w),
    .restart_i(level_chg),
    .pulse_o  (pulse_o),
    .toggle_o (toggle_o)
  );

  assign level_o = level_w;

endmodule

// File: tb/step_rate_pulser_test.sv
module step_rate_pulser_test;

  localparam int unsigned DIV = 2_500_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up = 1'b0;
  logic       dn = 1'b0;
  logic       pulse;
  logic       toggle;
  logic [3:0] level;

  always #5 clk = ~clk;

  step_rate_pulser #(.DIVISOR(DIV), .CNT_W(28), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .down_i(dn),
    .pulse_o(pulse), .toggle_o(toggle), .level_o(level)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Period table from R6, scaled by DIV.
  function automatic int exp_period(input int l);
    int b;
    case (l)
      0: b = 250_000_000;  1: b = 200_000_000;  2: b = 175_000_000;
      3: b = 150_000_000;  4: b = 125_000_000;  5: b = 100_000_000;
      6: b = 75_000_000;   7: b = 62_500_000;   8: b = 50_000_000;
      9: b = 35_000_000;   10: b = 25_000_000;  default: b = 10_000_000;
    endcase
    exp_period = (b / DIV == 0) ? 1 : b / DIV;
  endfunction

  // Behavioural reference model stepped on every rising edge.
  int m_lvl, m_cnt, m_p;
  bit m_pulse, m_tog;
  bit u1, u2, u3, d1, d2, d3, rs1, rs2;
  bit m_hold, ur, dr, chg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_cnt = 0; m_pulse = 0; m_tog = 0;
      u1 = 0; u2 = 0; u3 = 0; d1 = 0; d2 = 0; d3 = 0; rs1 = 0; rs2 = 0;
    end else begin
      m_hold = !rs2;
      rs2 = rs1;
      rs1 = 1'b1;
      if (m_hold) begin
        m_lvl = 0; m_cnt = 0; m_pulse = 0; m_tog = 0;
        u1 = 0; u2 = 0; u3 = 0; d1 = 0; d2 = 0; d3 = 0;
      end else begin
        ur = u2 && !u3;
        dr = d2 && !d3;
        m_p = exp_period(m_lvl);
        chg = 1'b0;
        if (ur && !dr && m_lvl < 10) begin
          m_lvl++; chg = 1'b1;
        end else if (dr && !ur && m_lvl > 0) begin
          m_lvl--; chg = 1'b1;
        end
        if (chg) begin
          m_cnt = 0; m_pulse = 0;
        end else if (m_cnt == m_p) begin
          m_cnt = 0; m_pulse = 1; m_tog = !m_tog;
        end else begin
          m_cnt++; m_pulse = 0;
        end
        u3 = u2; u2 = u1; u1 = up;
        d3 = d2; d2 = d1; d1 = dn;
      end
    end
  end

  // Every-cycle comparison and watchdog.
  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      check(int'(level) == m_lvl, "R2 R3 R4 R5 R9", "level vs model", int'(level), m_lvl);
      check(pulse == m_pulse, "R6 R8", "pulse vs model", int'(pulse), int'(m_pulse));
      check(toggle == m_tog, "R7", "toggle vs model", int'(toggle), int'(m_tog));
    end
    if (cyc > 100_000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100_000);
      finish_run();
    end
  end

  task automatic press(input bit down_btn, input int hold);
    if (down_btn) dn = 1'b1; else up = 1'b1;
    repeat (hold) @(negedge clk);
    up = 1'b0;
    dn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // Cycles from the current falling edge until the strobe is seen.
  task automatic cycles_to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < 2000);
  endtask

  initial begin
    int n;
    int k;
    bit t0;
    repeat (4) @(negedge clk);
    check(level == 4'd0, "R1", "level in reset", int'(level), 0);
    check(pulse == 1'b0, "R1", "pulse in reset", int'(pulse), 0);
    check(toggle == 1'b0, "R1", "toggle in reset", int'(toggle), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // Strobe spacing at level 0 and toggle inversion.
    cycles_to_pulse(n);
    t0 = toggle;
    cycles_to_pulse(n);
    check(n == exp_period(0) + 1, "R6", "spacing at level 0", n, exp_period(0) + 1);
    check(toggle == !t0, "R7", "toggle after strobe", int'(toggle), int'(!t0));

    // Held button counts once.
    press(1'b0, 8);
    check(level == 4'd1, "R2", "held up counts once", int'(level), 1);

    // Latency of three edges, then the restart on a level change.
    up = 1'b1;
    @(negedge clk);
    check(level == 4'd1, "R9", "level after 1 edge", int'(level), 1);
    @(negedge clk);
    check(level == 4'd1, "R9", "level after 2 edges", int'(level), 1);
    @(negedge clk);
    check(level == 4'd2, "R9", "level after 3 edges", int'(level), 2);
    up = 1'b0;
    cycles_to_pulse(n);
    check(n == exp_period(2) + 1, "R8", "first strobe after change", n, exp_period(2) + 1);

    // Climb past the top step.
    for (int i = 0; i < 10; i++) press(1'b0, 2);
    check(level == 4'd10, "R4", "saturate at 10", int'(level), 10);
    cycles_to_pulse(n);
    cycles_to_pulse(n);
    check(n == exp_period(10) + 1, "R6", "spacing at level 10", n, exp_period(10) + 1);

    press(1'b1, 3);
    check(level == 4'd9, "R3", "down step", int'(level), 9);

    // Simultaneous edges cancel.
    up = 1'b1;
    dn = 1'b1;
    repeat (3) @(negedge clk);
    up = 1'b0;
    dn = 1'b0;
    repeat (5) @(negedge clk);
    check(level == 4'd9, "R5", "both edges ignored", int'(level), 9);

    for (int i = 0; i < 12; i++) press(1'b1, 2);
    check(level == 4'd0, "R4", "saturate at 0", int'(level), 0);

    // Toggle parity over a window at level 0.
    t0 = toggle;
    k = 0;
    for (int i = 0; i < 350; i++) begin
      @(negedge clk);
      if (pulse) k++;
    end
    check(toggle == (t0 ^ k[0]), "R7", "toggle parity", int'(toggle), int'(t0 ^ k[0]));
    check(k == 3 || k == 4, "R6", "strobes in 350 cycles", k, 3);

    finish_run();
  end

endmodule